// File: doc/BRIEF.md
# Twisted-Ring Decade Counter with Seven-Segment Decode

This block counts one decimal digit. The count lives in a five-flop twisted-ring register, where each advance shifts the inverted top bit into the bottom. The ring state is decoded straight into seven active-high segment lines that can drive one display digit. Two slow control inputs, a count clock and a count inhibit, are sampled by the fast system clock through synchronizers, and their edges are detected there. A count happens on a rising count clock while inhibit is low, or on a falling inhibit while the count clock is high. The second path lets the inhibit pin act as a negative-edge clock.

A display-enable input gates all seven segment lines and is also repeated on its own output. A separate copy of segment c ignores the gate. A carry output is high for digits 0 to 4 and low for 5 to 9, so its rising edge marks the wrap from 9 to 0. Ring states outside the ten legal ones are sent back to zero on the next advance. All pins are plain control or status lines, so there is no handshake or back-pressure at the edge of the block.

Top module: `decade_ring_counter`

## Requirements
- R1: The ring holds, for digits 0 to 9 in order, the values 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000 and 10000. Ten advances from any digit return to the same digit.
- R2: While `rst` is high at a system clock edge, the count becomes 0 and stays at 0 whatever the count inputs do.
- R3: A rising edge of `count_clk` while `count_inh` is low advances the count by one, and 9 wraps to 0. Both inputs pass through two synchronizer flops. An input change set up before clock edge k shows in the outputs after edge k+2.
- R4: No count happens on a falling `count_clk`, on a rising `count_inh`, on a falling `count_inh` while `count_clk` is low, or on any `count_clk` edge while `count_inh` is high.
- R5: A falling edge of `count_inh` while `count_clk` is high advances the count by one. A rising clock and a falling inhibit seen in the same cycle give exactly one advance.
- R6: A ring value outside the ten legal ones loads 0 on the next advance. The ring always holds a legal value.
- R7: Segment bit 0 is a, bit 1 b and so on up to bit 6 g. The digits 0 to 9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R8: With `disp_en` low, `seg` is all zero. `disp_en_out` always equals `disp_en`. `seg_c_ungated` equals segment c of the current digit (bit 2 of the R7 pattern) whatever the value of `disp_en`.
- R9: `carry_out` is the inverse of the ring's top bit. It is high for digits 0 to 4 and low for digits 5 to 9.
- R10: If reset and an advance fall on the same system clock edge, reset wins and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high clear to digit 0 |
| count_clk | input | 1 | Counting clock; its rising edge counts |
| count_inh | input | 1 | Count inhibit; its falling edge counts while count_clk is high |
| disp_en | input | 1 | Display enable that gates the segment lines |
| seg | output | 7 | Gated segments, bit 0 = a through bit 6 = g |
| seg_c_ungated | output | 1 | Segment c without display gating |
| carry_out | output | 1 | Inverted top ring bit |
| disp_en_out | output | 1 | Copy of disp_en |

## Verification
The hardest case to reach from the ports is an advance and a reset landing on the same system clock edge. The bench gets there by counting synchronizer stages: it raises `count_clk` and then asserts `rst` exactly two edges later, so the advance and the reset land together. A released reset then shows whether reset won. Illegal ring values cannot be reached from the ports at all, so an in-design property covers R6. Across the inhibit and negative-edge-clock paths, the bench walks every ordering of the two input edges.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  localparam int RING_W = 5;
  localparam int DIGITS = 2 * RING_W;
  localparam int DIG_W  = $clog2(DIGITS);
  localparam int SEG_W  = 7;

  typedef logic [RING_W-1:0] ring_t;
  typedef logic [DIG_W-1:0]  digit_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // Legal twisted-ring values have at most one boundary between adjacent bits.
  function automatic logic ring_legal(ring_t q);
    int bounds;
    bounds = 0;
    for (int i = 0; i < RING_W - 1; i++) begin
      if (q[i] != q[i+1]) bounds++;
    end
    return (bounds <= 1);
  endfunction

  // Digit from a legal ring value: filling phase counts ones, draining phase counts down.
  function automatic digit_t ring_digit(ring_t q);
    int ones;
    ones = $countones(q);
    if (!q[RING_W-1]) return digit_t'(ones);
    else              return digit_t'(DIGITS - ones);
  endfunction
endpackage

// File: rtl/jdc_edge_sync.sv
module jdc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic level,
  output logic rose,
  output logic fell
);
  // STAGES synchronizer flops plus one history flop for edge detection.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rose  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fell  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/jdc_johnson_ring.sv
module jdc_johnson_ring
  import jdc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  output ring_t q
);
  ring_t nxt;

  always_comb begin
    if (!ring_legal(q)) nxt = '0;
    else                nxt = {q[RING_W-2:0], ~q[RING_W-1]};
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (adv) q <= nxt;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (q == '0)); // R2
  AST_LEGAL_RING: assert property (@(posedge clk) disable iff (rst) ring_legal(q)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(q)); // R4
endmodule

// File: rtl/jdc_seg_decode.sv
module jdc_seg_decode
  import jdc_pkg::*;
(
  input  digit_t digit,
  output seg_t   seg
);
  always_comb begin
    case (digit)
      digit_t'(0): seg = 7'h3F;
      digit_t'(1): seg = 7'h06;
      digit_t'(2): seg = 7'h5B;
      digit_t'(3): seg = 7'h4F;
      digit_t'(4): seg = 7'h66;
      digit_t'(5): seg = 7'h6D;
      digit_t'(6): seg = 7'h7D;
      digit_t'(7): seg = 7'h07;
      digit_t'(8): seg = 7'h7F;
      digit_t'(9): seg = 7'h6F;
      default:     seg = 7'h00;
    endcase
  end
endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter
  import jdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_clk,
  input  logic             count_inh,
  input  logic             disp_en,
  output logic [SEG_W-1:0] seg,
  output logic             seg_c_ungated,
  output logic             carry_out,
  output logic             disp_en_out
);
  logic   clk_lvl, clk_rose, clk_fell;
  logic   inh_lvl, inh_rose, inh_fell;
  logic   adv;
  ring_t  ring;
  digit_t digit;
  seg_t   raw_seg;

  jdc_edge_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk(clk), .din(count_clk), .level(clk_lvl), .rose(clk_rose), .fell(clk_fell)
  );

  jdc_edge_sync #(.STAGES(SYNC_STAGES)) u_inh_sync (
    .clk(clk), .din(count_inh), .level(inh_lvl), .rose(inh_rose), .fell(inh_fell)
  );

  // Rising clock with inhibit low, or falling inhibit with clock high.
  assign adv = (clk_rose & ~inh_lvl) | (inh_fell & clk_lvl);

  jdc_johnson_ring u_ring (
    .clk(clk), .rst(rst), .adv(adv), .q(ring)
  );

  assign digit = ring_digit(ring);

  jdc_seg_decode u_dec (
    .digit(digit), .seg(raw_seg)
  );

  assign seg           = disp_en ? raw_seg : '0;
  assign seg_c_ungated = raw_seg[2];
  assign carry_out     = ~ring[RING_W-1];
  assign disp_en_out   = disp_en;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst) adv |=> (digit == (($past(digit) == digit_t'(DIGITS-1)) ? digit_t'(0) : digit_t'($past(digit) + 1'b1)))); // R3
  AST_NO_EDGE_ADV: assert property (@(posedge clk) disable iff (rst) (clk_fell || inh_rose) |-> !adv); // R4
  AST_SEG_GATED: assert property (@(posedge clk) disable iff (rst) !disp_en |-> (seg == '0)); // R8
  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (rst) carry_out == (digit < digit_t'(RING_W))); // R9
endmodule

// File: tb/decade_ring_counter_test.sv
`timescale 1ns/1ps
module decade_ring_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       count_clk = 1'b0;
  logic       count_inh = 1'b0;
  logic       disp_en = 1'b1;
  logic [6:0] seg;
  logic       seg_c_ungated, carry_out, disp_en_out;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  decade_ring_counter uut (
    .clk(clk), .rst(rst), .count_clk(count_clk), .count_inh(count_inh),
    .disp_en(disp_en), .seg(seg), .seg_c_ungated(seg_c_ungated),
    .carry_out(carry_out), .disp_en_out(disp_en_out)
  );

  function automatic logic [6:0] pattern(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_outputs(string req);
    logic [6:0] p;
    p = pattern(model);
    chk({req, " seg"}, int'(seg), disp_en ? int'(p) : 0);
    chk({req, " carry R9"}, int'(carry_out), (model < 5) ? 1 : 0);
    chk({req, " seg_c R8"}, int'(seg_c_ungated), int'(p[2]));
    chk({req, " den_out R8"}, int'(disp_en_out), int'(disp_en));
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clk();
    count_clk = 1'b1; settle();
    count_clk = 1'b0; settle();
  endtask

  task automatic t_reset();
    rst = 1'b1; settle();
    count_clk = 1'b1; settle();
    count_clk = 1'b0; settle();
    model = 0;
    expect_outputs("R2 reset holds zero");
    rst = 1'b0; settle();
    expect_outputs("R2 after release");
  endtask

  task automatic t_count();
    for (int i = 0; i < 12; i++) begin
      count_clk = 1'b1; settle();
      model = (model + 1) % 10;
      expect_outputs("R3 R1 R7 rising clock advance");
      count_clk = 1'b0; settle();
      expect_outputs("R4 falling clock no advance");
    end
  endtask

  task automatic t_full_cycle();
    int start;
    start = model;
    for (int i = 0; i < 10; i++) pulse_clk();
    model = start;
    expect_outputs("R6 R1 ten advances return");
  endtask

  task automatic t_inhibit();
    count_inh = 1'b1; settle();
    expect_outputs("R4 rising inhibit no advance");
    for (int i = 0; i < 3; i++) pulse_clk();
    expect_outputs("R4 inhibited clock edges");
    count_inh = 1'b0; settle();
    expect_outputs("R4 falling inhibit with clock low");
  endtask

  task automatic t_inh_as_clock();
    count_inh = 1'b1; settle();
    count_clk = 1'b1; settle();
    expect_outputs("R4 clock rise under inhibit");
    for (int i = 0; i < 4; i++) begin
      count_inh = 1'b0; settle();
      model = (model + 1) % 10;
      expect_outputs("R5 inhibit falling edge advance");
      count_inh = 1'b1; settle();
      expect_outputs("R4 inhibit rising no advance");
    end
    count_clk = 1'b0; settle();
    count_inh = 1'b0; settle();
    expect_outputs("R4 inhibit release clock low");
  endtask

  task automatic t_simultaneous();
    count_inh = 1'b1; settle();
    count_clk = 1'b1; count_inh = 1'b0; settle();
    model = (model + 1) % 10;
    expect_outputs("R5 simultaneous edges single advance");
    count_clk = 1'b0; settle();
  endtask

  task automatic t_display();
    disp_en = 1'b0; settle();
    expect_outputs("R8 display off");
    for (int i = 0; i < 10; i++) begin
      pulse_clk();
      model = (model + 1) % 10;
      expect_outputs("R8 gated digits ungated c");
    end
    disp_en = 1'b1; settle();
    expect_outputs("R8 display back on");
  endtask

  task automatic t_reset_priority();
    while (model != 3) begin
      pulse_clk();
      model = (model + 1) % 10;
    end
    expect_outputs("R10 setup digit 3");
    count_clk = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    settle();
    model = 0;
    expect_outputs("R10 reset beats advance");
    count_clk = 1'b0; settle();
    expect_outputs("R10 stays zero");
  endtask

  initial begin
    t_reset();
    t_count();
    t_full_cycle();
    t_inhibit();
    t_inh_as_clock();
    t_simultaneous();
    t_display();
    t_reset_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule